// File: doc/BRIEF.md
# Sliding-Window Occupancy Trigger

This block watches a stream of digitized samples and raises a trigger when enough of the recent samples are significant. Each accepted sample is compared with a programmable bin threshold. A sample that is strictly above the threshold counts as "fired". The fired bits pass through a 256-stage one-bit delay line. A running count holds how many fired bits lie inside a window of the most recent accepted samples. When that count is above a programmable occupancy threshold, and the window has been completely filled since the last reset or window change, the block pulses its trigger output for one clock.

The window length is chosen at run time. The block selects one tap of the delay line and uses the bit at that tap as the bit that leaves the window. The count is kept up to date step by step: it goes up when a fired bit enters, goes down when a fired bit leaves at the selected tap, and stays the same when both happen on one step. When the window selection changes, the block drops its history and fills the window again.

Samples arrive on a valid/ready interface. The block never applies back-pressure in operation. `s_ready` is low while reset is applied and during the first clock after it; from then on it stays high. A sample is accepted on a rising edge where `s_valid` and `s_ready` are both high, except in the window-change case described in R7. The thresholds and the window select are plain control inputs and are read on every clock.

Top module: `occ_trig`

## Requirements
- R1: A sample is fired only when it is strictly greater than `bin_thr`, compared as unsigned numbers. A sample equal to `bin_thr` is not fired.
- R2: The window holds the most recent `win_sel`+1 accepted samples. `win_sel` ranges from 0 (a window of 1 sample) to 255 (a window of 256 samples).
- R3: The in-window count is exactly the number of fired samples among those window samples. It is 9 bits wide, so it reaches 256 for a full 256-sample window without overflowing. It changes by at most one per accepted sample.
- R4: `trig` is high for exactly the one clock after an accepted sample when two conditions hold: the count, including that sample, is strictly greater than `occ_thr`, and the window is filled. In every other clock `trig` is low.
- R5: A clock without an accepted sample leaves the delay line and the count unchanged. `trig` is low in the following clock.
- R6: A synchronous active-high `rst` clears the delay line, the count and the fill state, and holds `trig` and `s_ready` low. After reset, `trig` stays low until `win_sel`+1 samples have been accepted.
- R7: In a clock where `win_sel` differs from its value in the previous clock, the block drops its history and clears the count. Any sample presented in that clock is dropped. `trig` then stays low until `win_sel`+1 new samples have been accepted.
- R8: With `win_sel`=119 and `occ_thr`=11, the trigger fires on the sample that brings the number of fired samples in the last 120 samples to 12. It does not fire while that number is 11 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | A sample is presented on `s_sample` |
| s_ready | output | 1 | The block accepts a sample this clock |
| s_sample | input | 10 | Sample value, unsigned |
| bin_thr | input | 10 | A sample above this value is fired |
| occ_thr | input | 9 | The trigger needs an in-window count above this value |
| win_sel | input | 8 | Window length minus one |
| trig | output | 1 | Registered one-clock trigger pulse |

## Verification
The assertions assume that `rst` is asserted at the start of the run and that inputs change only away from the rising clock edge. They also assume that a change of `win_sel` is meant to restart the window, so the stall and step-size properties are gated on `win_sel` being unchanged. The stimulus changes every input at the falling edge. It changes `win_sel` only on purpose, either while valid samples are flowing or while reset is asserted, and the reference model drops the sample presented in a change cycle. Samples include values equal to the bin threshold, values on either side of it, and values at the ends of the range. Gaps in `s_valid` are mixed into long fired runs, so the window boundary is crossed both when the stream is dense and when it is sparse.

// File: rtl/occ_pkg.sv
package occ_pkg;

  // Per-clock control word shared by the counting stages.
  typedef struct packed {
    logic step;   // a sample is accepted this clock
    logic flush;  // history is dropped this clock
    logic enter;  // fired bit entering the window
    logic leave;  // fired bit leaving at the selected tap
  } occ_ctl_t;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/occ_bin_cmp.sv
module occ_bin_cmp #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] thr,
  output logic                fired
);
  always_comb fired = (sample > thr);
endmodule

// File: rtl/occ_tap_line.sv
module occ_tap_line #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  logic [DEPTH-1:0] line;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_head
      always_comb d = din;
    end else begin : g_body
      always_comb d = line[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clear) line[g] <= 1'b0;
      else if (shift)   line[g] <= d;
    end
  end

  // Bit currently at the far end of the window: it leaves on the next shift.
  always_comb tap = line[sel];
endmodule

// File: rtl/occ_window_count.sv
module occ_window_count
  import occ_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  occ_ctl_t         ctl,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             full_nxt
);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill_nxt;

  always_comb begin
    cnt_nxt  = cnt;
    fill_nxt = fill;
    if (ctl.flush) begin
      cnt_nxt  = '0;
      fill_nxt = '0;
    end else if (ctl.step) begin
      unique case ({ctl.enter, ctl.leave})
        2'b10:   cnt_nxt = cnt + CNT_W'(1);
        2'b01:   cnt_nxt = cnt - CNT_W'(1);
        default: cnt_nxt = cnt;
      endcase
      fill_nxt = (fill == FILL_MAX) ? fill : fill + CNT_W'(1);
    end
    full_nxt = ctl.step && !ctl.flush && (fill_nxt >= win_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fill <= '0;
    end else begin
      cnt  <= cnt_nxt;
      fill <= fill_nxt;
    end
  end
endmodule

// File: rtl/occ_trig.sv
module occ_trig
  import occ_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned DEPTH    = 256,
  localparam int unsigned SEL_W   = $clog2(DEPTH),
  localparam int unsigned CNT_W   = cnt_bits(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic [SAMPLE_W-1:0] bin_thr,
  input  logic [CNT_W-1:0]    occ_thr,
  input  logic [SEL_W-1:0]    win_sel,
  output logic                trig
);
  logic             rdy_q;
  logic [SEL_W-1:0] sel_q;
  logic             fired;
  logic             tap_bit;
  occ_ctl_t         ctl;
  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] occ_cnt;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             full_nxt;
  logic             trig_q;

  // The selection register follows win_sel on every clock, reset included,
  // so leaving reset never looks like a window change.
  always_ff @(posedge clk) begin
    sel_q <= win_sel;
    rdy_q <= !rst;
  end

  occ_bin_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .sample (s_sample),
    .thr    (bin_thr),
    .fired  (fired)
  );

  always_comb begin
    ctl.flush = (win_sel != sel_q);
    ctl.step  = s_valid && rdy_q && !ctl.flush;
    ctl.enter = fired;
    ctl.leave = tap_bit;
    win_len   = CNT_W'(sel_q) + CNT_W'(1);
  end

  occ_tap_line #(.DEPTH(DEPTH)) u_line (
    .clk   (clk),
    .rst   (rst),
    .clear (ctl.flush),
    .shift (ctl.step),
    .din   (fired),
    .sel   (sel_q),
    .tap   (tap_bit)
  );

  occ_window_count #(.DEPTH(DEPTH)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .win_len  (win_len),
    .cnt      (occ_cnt),
    .fill     (fill_cnt),
    .cnt_nxt  (cnt_nxt),
    .full_nxt (full_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= full_nxt && (cnt_nxt > occ_thr);
  end

  assign trig    = trig_q;
  assign s_ready = rdy_q;
endmodule

// File: rtl/occ_trig_chk.sv
module occ_trig_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned SEL_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic [SEL_W-1:0] win_sel,
  input logic [SEL_W-1:0] sel_q,
  input logic [CNT_W-1:0] occ_cnt,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             trig
);
  logic [CNT_W:0] wlen;
  always_comb wlen = (CNT_W+1)'(sel_q) + (CNT_W+1)'(1);

  a_r3_count_in_window: assert property (@(posedge clk) disable iff (rst)
    (CNT_W+1)'(occ_cnt) <= wlen);

  a_r3_count_unit_step: assert property (@(posedge clk) disable iff (rst)
    (win_sel == sel_q) |=> ((occ_cnt == $past(occ_cnt)) ||
                            (occ_cnt == $past(occ_cnt) + 1'b1) ||
                            (occ_cnt + 1'b1 == $past(occ_cnt))));

  a_r4_trig_after_accept: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(s_valid && s_ready));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!s_valid && (win_sel == sel_q)) |=> ($stable(occ_cnt) && !trig));

  a_r6_trig_needs_fill: assert property (@(posedge clk) disable iff (rst)
    trig |-> ((CNT_W+1)'(fill_cnt) >= wlen));

  a_r7_change_flushes: assert property (@(posedge clk) disable iff (rst)
    (win_sel != sel_q) |=> (occ_cnt == '0 && fill_cnt == '0 && !trig));
endmodule

bind occ_trig occ_trig_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .win_sel  (win_sel),
  .sel_q    (sel_q),
  .occ_cnt  (occ_cnt),
  .fill_cnt (fill_cnt),
  .trig     (trig)
);

// File: tb/test_occ_trig.sv
module test_occ_trig;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [9:0] s_sample = '0;
  logic [9:0] bin_thr = '0;
  logic [8:0] occ_thr = '0;
  logic [7:0] win_sel = '0;
  logic       trig;

  always #4 clk = ~clk;

  occ_trig i_occ_trig (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .bin_thr(bin_thr), .occ_thr(occ_thr),
    .win_sel(win_sel), .trig(trig)
  );

  typedef struct {
    int    cyc;
    logic  exp_trig;
    logic  exp_rdy;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nchk = 0;
  int    nfail = 0;
  bit    done = 0;

  // Settings applied together at the next falling edge.
  logic       t_rst = 1'b1;
  logic [9:0] t_bin = '0;
  logic [8:0] t_occ = '0;
  logic [7:0] t_win = '0;
  string      t_tag = "R6";

  // Reference model state.
  bit         hist[$];
  logic       m_rdy = 1'b0;
  logic [7:0] m_selq = '0;

  always @(posedge clk) cyc++;

  task automatic drive(input logic v, input int smp);
    item_t it;
    bit acc, fl, f;
    int w, c;
    @(negedge clk);
    rst = t_rst; bin_thr = t_bin; occ_thr = t_occ; win_sel = t_win;
    s_valid = v; s_sample = 10'(smp);
    it.cyc = cyc; it.tag = t_tag; it.exp_trig = 1'b0; it.exp_rdy = !t_rst;
    fl  = !t_rst && (t_win != m_selq);
    acc = !t_rst && v && m_rdy && !fl;
    if (t_rst || fl) hist.delete();
    else if (acc) begin
      f = (10'(smp) > t_bin);             // R1 strict compare
      hist.push_front(f);
      if (hist.size() > 256) void'(hist.pop_back());
      w = int'(t_win) + 1;                // R2 window length
      if (hist.size() >= w) begin
        c = 0;
        for (int k = 0; k < w; k++) c += hist[k];
        it.exp_trig = (c > int'(t_occ));
      end
    end
    m_rdy = !t_rst; m_selq = t_win;
    q.push_back(it);
  endtask

  // Monitor: compares each expected item one rising edge after it was applied.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc < cyc) begin
      item_t it;
      it = q.pop_front();
      nchk++;
      if (trig !== it.exp_trig || s_ready !== it.exp_rdy) begin
        nfail++;
        $display("FAIL %s cycle %0d: trig=%b s_ready=%b expected trig=%b s_ready=%b",
                 it.tag, cyc, trig, s_ready, it.exp_trig, it.exp_rdy);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R6: reset state, then hold-off right after reset
    t_tag = "R6"; t_rst = 1; t_win = 8'd3; t_bin = 10'd100; t_occ = 9'd0;
    repeat (4) drive(1, 500);
    t_rst = 0;
    drive(1, 500);                        // s_ready still low: dropped
    for (int i = 0; i < 6; i++) drive(1, 500);

    // R1: equal to threshold is not fired, one above is
    t_tag = "R1"; t_rst = 1; drive(0, 0); t_rst = 0; drive(0, 0);
    for (int i = 0; i < 5; i++) drive(1, 100);
    drive(1, 101); drive(1, 99); drive(1, 0); drive(1, 1023);
    for (int i = 0; i < 5; i++) drive(1, 100);

    // R8: reference configuration, window change from 3 to 119 (R7)
    t_tag = "R8"; t_win = 8'd119; t_occ = 9'd11; t_bin = 10'd50;
    for (int i = 0; i < 400; i++)
      drive(1, ((i % 10 == 0) || (i % 37 == 5)) ? 300 : 50);
    for (int i = 0; i < 300; i++)
      drive(1, (i % 11 == 0) ? 51 : 20);

    // R5: gaps in valid
    t_tag = "R5"; t_win = 8'd15; t_occ = 9'd3;
    for (int i = 0; i < 200; i++)
      drive((i % 3) != 1, (i % 4 == 0) ? 800 : 10);

    // R2/R3: full 256-sample window, count reaches 256
    t_tag = "R3"; t_win = 8'd255; t_occ = 9'd255; t_bin = 10'd0;
    for (int i = 0; i < 300; i++) drive(1, 1);
    t_occ = 9'd200;
    for (int i = 0; i < 300; i++) drive(1, (i % 5 == 0) ? 0 : 7);

    // R2: single-sample window
    t_tag = "R2"; t_win = 8'd0; t_occ = 9'd0; t_bin = 10'd9;
    for (int i = 0; i < 40; i++) drive(i % 7 != 3, (i % 2) ? 10 : 9);

    // R4: threshold steps and random data
    t_tag = "R4"; t_win = 8'd31; t_bin = 10'd500;
    for (int i = 0; i < 600; i++) begin
      t_occ = 9'(i / 60);
      drive(($urandom % 8) != 0, int'($urandom % 1024));
    end

    // R7: window change mid-stream drops the presented sample
    t_tag = "R7";
    for (int r = 0; r < 6; r++) begin
      t_win = 8'(5 + r * 9); t_occ = 9'd2; t_bin = 10'd200;
      for (int i = 0; i < 80; i++) drive(1, (i % 3 == 0) ? 900 : 100);
    end

    // R6: reset in the middle of a dense run
    t_tag = "R6"; t_win = 8'd9; t_occ = 9'd4; t_bin = 10'd0;
    for (int i = 0; i < 30; i++) drive(1, 5);
    t_rst = 1; drive(1, 5); drive(1, 5); t_rst = 0;
    for (int i = 0; i < 30; i++) drive(1, 5);

    drive(0, 0); drive(0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule